// File: doc/BRIEF.md
# Power Mode Sequencer with Oscillator and PLL Enable Resolution

This block holds a byte-wide power control register, runs the sequence that moves the device between its four operating modes, and decides whether the high-frequency oscillator and the PLL may run. Software writes the register to request a low-power mode. A Power Save request can take effect at once. It can also be held back until the CPU executes a WAIT instruction, which reaches the block as a one-cycle strobe. Idle and Halt requests are always held until that strobe.

A mode change goes through a handshake with the clock system. The sequencer raises an internal switch request, and the new mode appears on the mode output only after the clock system pulses a switch-complete input. A hardware wake-up event cancels any request at once and returns the device to Active. While the device is in Power Save or Idle, software disable bits and a hardware override can stop the oscillator and the PLL. The hardware override acts when the radio link controller reports that it is asleep. A separate power-down input can also stop the PLL. All control pins are plain levels or strobes, and there is no streaming interface.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the mode is Active (code 0), and both enables are 1 while pll_pwrdn is low. Mode codes are Active=0, Power Save=1, Idle=2, Halt=3.
- R2: The register layout from bit 7 down to bit 0 is: PLL hardware-control, oscillator hardware-control, PLL disable, oscillator disable, defer-to-WAIT, HALT, IDLE, PSM. Bits 7 to 3 read back exactly as they were last written.
- R3: A write with bit 0 set and bit 3 clear, made in Active with no switch in progress, starts a switch to Power Save. The mode output and read bit 0 change to Power Save one cycle after the sw_done pulse, and not before.
- R4: A write with bits 0 and 3 both set does not start a switch. Power Save is requested at the next wait_exec strobe, and sw_done pulses before that strobe are ignored.
- R5: A write to IDLE (bit 1) only takes effect if bit 3 is set in the same write. Otherwise IDLE reads 0 and a WAIT does not enter Idle. When it takes effect, IDLE reads 1 and the next WAIT followed by sw_done enters Idle.
- R6: A wake_evt pulse clears PSM, IDLE, HALT and any deferred Power Save request, and cancels a switch in progress. The mode is Active on the following cycle. Bits 7 to 3 are kept.
- R7: In Power Save, Idle or Halt, writing 0 to the bit of the current mode returns the mode to Active on the next cycle.
- R8: In Power Save or Idle, bit 4 set turns off the oscillator and bit 5 set turns off the PLL, whatever the value of lc_sleep.
- R9: In Power Save or Idle, when lc_sleep is 1, bit 6 set turns off the oscillator and bit 7 set turns off the PLL. When lc_sleep is 0 these bits have no effect.
- R10: In Active both enables are on. In Halt both are off. Bits 7 to 4 and lc_sleep have no effect in these two modes.
- R11: pll_pwrdn high forces pll_en low in every mode and never changes osc_en.
- R12: pll_en is never 1 while osc_en is 0.
- R13: A HALT write (bit 2) is entered at the next WAIT. When more than one request is pending at a WAIT, Halt wins over Idle, and Idle wins over a deferred Power Save.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| wait_exec | input | 1 | One-cycle strobe when a WAIT instruction executes |
| wake_evt | input | 1 | Hardware wake-up event pulse |
| lc_sleep | input | 1 | Radio link controller is asleep |
| pll_pwrdn | input | 1 | PLL power-down control level |
| sw_done | input | 1 | Clock system reports the mode switch complete |
| mode | output | 2 | Current operating mode code |
| osc_en | output | 1 | High-frequency oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The bench sweeps every combination of the four gating bits, lc_sleep and pll_pwrdn in each of the four modes. A design that let the gating bits act in Active or Halt would show a wrong enable in that sweep, and so would one that let the hardware override act while the link controller is awake. The sequencing checks cover the following cases. They catch a PSM bit that reads 1 before sw_done, a deferred request that starts without a WAIT, and an IDLE write accepted without the defer bit. They also catch a wake-up that leaves a stale Power Save request behind and a WAIT that resolves competing requests in the wrong order.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W = 8;

  localparam int B_PSM  = 0;
  localparam int B_IDLE = 1;
  localparam int B_HALT = 2;
  localparam int B_WBPS = 3;
  localparam int CFG_LO = 3;
  localparam int SEQ_W  = B_WBPS + 1;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_PSAVE  = 2'd1,
    MODE_IDLE   = 2'd2,
    MODE_HALT   = 2'd3
  } pmc_mode_e;

  typedef struct packed {
    logic pll_hwc;
    logic osc_hwc;
    logic pll_dis;
    logic osc_dis;
    logic wbps;
  } pmc_cfg_t;
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
  import pmc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_W-1:CFG_LO]   wr_cfg,
  input  logic                    wake_evt,
  output pmc_cfg_t                cfg
);
  // configuration bits survive wake-up; only a write changes them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en && !wake_evt) begin
      cfg <= pmc_cfg_t'(wr_cfg);
    end
  end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_lo,
  input  logic             wait_exec,
  input  logic             wake_evt,
  input  logic             sw_done,
  output pmc_mode_e        mode,
  output logic [2:0]       status
);
  pmc_mode_e mode_q, tgt_q;
  logic busy_q, psm_pend_q, idle_q, halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_ACTIVE;
      tgt_q      <= MODE_ACTIVE;
      busy_q     <= 1'b0;
      psm_pend_q <= 1'b0;
      idle_q     <= 1'b0;
      halt_q     <= 1'b0;
    end else if (wake_evt) begin
      mode_q     <= MODE_ACTIVE;
      busy_q     <= 1'b0;
      psm_pend_q <= 1'b0;
      idle_q     <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      if (busy_q && sw_done) begin
        mode_q <= tgt_q;
        busy_q <= 1'b0;
      end
      if (wr_en) begin
        if (wr_lo[B_PSM]) begin
          if (mode_q == MODE_ACTIVE && !busy_q) begin
            if (wr_lo[B_WBPS]) begin
              psm_pend_q <= 1'b1;
            end else begin
              busy_q <= 1'b1;
              tgt_q  <= MODE_PSAVE;
            end
          end
        end else begin
          psm_pend_q <= 1'b0;
          if (mode_q == MODE_PSAVE) mode_q <= MODE_ACTIVE;
        end
        idle_q <= wr_lo[B_IDLE] & wr_lo[B_WBPS];
        if (!wr_lo[B_IDLE] && mode_q == MODE_IDLE) mode_q <= MODE_ACTIVE;
        halt_q <= wr_lo[B_HALT];
        if (!wr_lo[B_HALT] && mode_q == MODE_HALT) mode_q <= MODE_ACTIVE;
      end else if (wait_exec && !busy_q && mode_q == MODE_ACTIVE) begin
        if (halt_q) begin
          busy_q <= 1'b1;
          tgt_q  <= MODE_HALT;
        end else if (idle_q) begin
          busy_q <= 1'b1;
          tgt_q  <= MODE_IDLE;
        end else if (psm_pend_q) begin
          busy_q     <= 1'b1;
          tgt_q      <= MODE_PSAVE;
          psm_pend_q <= 1'b0;
        end
      end
    end
  end

  assign mode   = mode_q;
  assign status = {halt_q, idle_q, mode_q == MODE_PSAVE};

  AST_ENTRY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_ACTIVE && $past(mode_q) == MODE_ACTIVE) |-> $past(busy_q && sw_done)); // R3
  AST_DEFER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && $past(wr_en)) |-> !$past(wr_lo[B_WBPS])); // R4
  AST_IDLE_NEEDS_WBPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(wr_en && wr_lo[B_WBPS])); // R5
  AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (mode_q == MODE_ACTIVE && !busy_q && status == 3'b000)); // R6
endmodule

// File: rtl/pmc_clk_resolve.sv
module pmc_clk_resolve
  import pmc_pkg::*;
(
  input  pmc_mode_e mode,
  input  pmc_cfg_t  cfg,
  input  logic      lc_sleep,
  input  logic      pll_pwrdn,
  output logic      osc_en,
  output logic      pll_en
);
  logic pll_mode_ok;

  always_comb begin
    unique case (mode)
      MODE_ACTIVE: begin
        osc_en      = 1'b1;
        pll_mode_ok = 1'b1;
      end
      MODE_HALT: begin
        osc_en      = 1'b0;
        pll_mode_ok = 1'b0;
      end
      default: begin
        // software disable wins; otherwise the radio sleep override applies
        osc_en      = !(cfg.osc_dis || (cfg.osc_hwc && lc_sleep));
        pll_mode_ok = !(cfg.pll_dis || (cfg.pll_hwc && lc_sleep));
      end
    endcase
    pll_en = pll_mode_ok && osc_en && !pll_pwrdn;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             wait_exec,
  input  logic             wake_evt,
  input  logic             lc_sleep,
  input  logic             pll_pwrdn,
  input  logic             sw_done,
  output logic [1:0]       mode,
  output logic             osc_en,
  output logic             pll_en
);
  pmc_cfg_t   cfg;
  pmc_mode_e  mode_w;
  logic [2:0] status;

  pmc_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_cfg   (wr_data[REG_W-1:CFG_LO]),
    .wake_evt (wake_evt),
    .cfg      (cfg)
  );

  pmc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_lo     (wr_data[SEQ_W-1:0]),
    .wait_exec (wait_exec),
    .wake_evt  (wake_evt),
    .sw_done   (sw_done),
    .mode      (mode_w),
    .status    (status)
  );

  pmc_clk_resolve u_res (
    .mode      (mode_w),
    .cfg       (cfg),
    .lc_sleep  (lc_sleep),
    .pll_pwrdn (pll_pwrdn),
    .osc_en    (osc_en),
    .pll_en    (pll_en)
  );

  assign rd_data = {cfg, status};
  assign mode    = mode_w;

  AST_HALT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_HALT) |-> (!osc_en && !pll_en)); // R10
  AST_ACTIVE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_ACTIVE && !pll_pwrdn) |-> (osc_en && pll_en)); // R10
  AST_PWRDN_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !pll_en); // R11
  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en); // R12
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wait_exec = 1'b0;
  logic wake_evt = 1'b0;
  logic lc_sleep = 1'b0;
  logic pll_pwrdn = 1'b0;
  logic sw_done = 1'b0;
  logic [1:0] mode;
  logic osc_en, pll_en;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wait_exec(wait_exec), .wake_evt(wake_evt), .lc_sleep(lc_sleep),
    .pll_pwrdn(pll_pwrdn), .sw_done(sw_done), .mode(mode), .osc_en(osc_en), .pll_en(pll_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_wait();
    @(negedge clk); wait_exec = 1'b1;
    @(negedge clk); wait_exec = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); sw_done = 1'b1;
    @(negedge clk); sw_done = 1'b0;
  endtask

  task automatic do_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  function automatic logic [7:0] lo_bits(input int m);
    case (m)
      1: return 8'h01;
      2: return 8'h0A;
      3: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  task automatic go_mode(input int m);
    lc_sleep = 1'b0; pll_pwrdn = 1'b0;
    do_wake();
    wr(8'h00);
    if (m != 0) begin
      wr(lo_bits(m));
      if (m != 1) do_wait();
      do_done();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 mode", mode, 0);
    check("R1 osc_en", osc_en, 1);
    check("R1 pll_en", pll_en, 1);

    wr(8'hF8);
    check("R2 readback", rd_data, 8'hF8);
    check("R2 mode unchanged", mode, 0);
    wr(8'h58);
    check("R2 readback 2", rd_data, 8'h58);
    wr(8'h00);

    wr(8'h01);
    check("R3 mode before done", mode, 0);
    check("R3 psm before done", rd_data[0], 0);
    do_done();
    check("R3 mode after done", mode, 1);
    check("R3 psm after done", rd_data, 8'h01);

    do_wake();
    wr(8'h09);
    check("R4 no start", mode, 0);
    check("R4 psm reads 0", rd_data, 8'h08);
    do_done();
    check("R4 done ignored", mode, 0);
    do_wait();
    check("R4 still switching", mode, 0);
    do_done();
    check("R4 entered after wait", mode, 1);

    do_wake();
    wr(8'h02);
    check("R5 idle ignored rd", rd_data, 8'h00);
    do_wait(); do_done();
    check("R5 idle ignored mode", mode, 0);
    wr(8'h0A);
    check("R5 idle rd", rd_data, 8'h0A);
    do_wait(); do_done();
    check("R5 idle mode", mode, 2);

    do_wake();
    check("R6 wake mode", mode, 0);
    check("R6 wake rd", rd_data, 8'h08);
    wr(8'h09);
    do_wake();
    do_wait(); do_done();
    check("R6 pending cancelled", mode, 0);
    wr(8'h01);
    do_wake();
    do_done();
    check("R6 switch cancelled", mode, 0);

    go_mode(1);
    wr(8'h00);
    check("R7 exit psave", mode, 0);
    go_mode(2);
    wr(8'h08);
    check("R7 exit idle", mode, 0);
    go_mode(3);
    check("R13 halt entered", mode, 3);
    wr(8'h00);
    check("R7 exit halt", mode, 0);

    do_wake(); wr(8'h0F); do_wait(); do_done();
    check("R13 halt first", mode, 3);
    do_wake(); wr(8'h0B); do_wait(); do_done();
    check("R13 idle over psave", mode, 2);
    do_wake(); wr(8'h09); do_wait(); do_done();
    check("R13 psave last", mode, 1);

    for (int m = 0; m < 4; m++) begin
      go_mode(m);
      for (int c = 0; c < 16; c++) begin
        for (int s = 0; s < 2; s++) begin
          for (int p = 0; p < 2; p++) begin
            logic eo, ep;
            wr({c[3:0], lo_bits(m)[3:0]});
            lc_sleep = s[0]; pll_pwrdn = p[0];
            @(negedge clk);
            if (m == 0) begin eo = 1'b1; ep = 1'b1; end
            else if (m == 3) begin eo = 1'b0; ep = 1'b0; end
            else begin
              eo = !(c[0] || (c[2] && s[0]));
              ep = !(c[1] || (c[3] && s[0]));
            end
            ep = ep && eo && !p[0];
            check("R8 R9 R10 sweep mode", mode, m);
            check("R8 R9 R10 R11 osc_en", osc_en, eo);
            check("R8 R9 R10 R11 R12 pll_en", pll_en, ep);
            if (pll_en && !osc_en) check("R12 pll without osc", 1, 0);
            lc_sleep = 1'b0; pll_pwrdn = 1'b0;
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule